// File: doc/BRIEF.md
# Load-Tracking Valley Count Regulator

This block holds the 4-bit target valley count for a quasi-resonant flyback controller. The count sets how many ringing zero crossings of the auxiliary winding are skipped before the power switch turns on again. A low count gives short off-times and high power. A high count stretches the off-time, which lowers the switching frequency at light load in small, jitter-free steps.

Three comparator flags report where the feedback voltage sits:
- below the low band,
- above the high band,
- above the load-jump level.

Two sticky flags collect the low-band and high-band events during each slow trigger period. On every trigger tick the count steps by at most one, based on those flags, and the flags then clear. A load jump skips the tick and forces the count back to one on the next clock.

Top module: `valley_count_reg`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `targetCount` equals 1.
- R2: If `belowLow` was high in any cycle since the previous tick, including the tick cycle itself, and `aboveHigh` was not, the count rises by one on the clock edge that samples `tick` high.
- R3: If `aboveHigh` was high in any cycle since the previous tick, including the tick cycle itself, and `belowLow` was not, the count falls by one on the clock edge that samples `tick` high.
- R4: A tick with no band event in its period leaves the count unchanged.
- R5: A tick whose period saw both a `belowLow` event and an `aboveHigh` event leaves the count unchanged.
- R6: Without a tick or a load jump, the count does not change, however long the band inputs stay high.
- R7: Band events are forgotten after each tick, so an event applies to one tick only.
- R8: The count saturates at 15 and does not wrap.
- R9: The count never falls below 1.
- R10: A clock edge that samples `aboveReset` high sets the count to 1, with or without a tick. This takes priority over any step.
- R11: `targetCount` is unsigned binary and always lies in the range 1 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| belowLow | input | 1 | Feedback voltage is below the low band |
| aboveHigh | input | 1 | Feedback voltage is above the high band |
| aboveReset | input | 1 | Feedback voltage is above the load-jump level |
| tick | input | 1 | One-cycle pulse from the slow trigger timebase |
| targetCount | output | 4 | Number of zero crossings to skip, unsigned binary, 1 to 15 |

## Verification
Every result of this block appears one clock edge after its cause.
- A tick step shows on the edge that samples `tick` high.
- A preset shows on the edge that samples `aboveReset` high.
- A captured band flag changes nothing visible until a later tick.

The bench drives each stimulus on a falling edge and compares `targetCount` on the next falling edge, exactly one rising edge later. This also catches a step that arrives early or late. Periods with no tick are compared in the same way, which confirms that the count has not moved.

// File: rtl/vcr_pkg.sv
package vcr_pkg;

  // Strobes passed from the control to the datapath for one clock cycle.
  typedef struct packed {
    logic preset;  // load-jump: force count to minimum
    logic inc;     // step count up by one
    logic dec;     // step count down by one
  } vcrStrobes_t;

endpackage

// File: rtl/vcr_ctrl.sv
module vcr_ctrl
  import vcr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        belowLow,
  input  logic        aboveHigh,
  input  logic        aboveReset,
  input  logic        tick,
  output vcrStrobes_t strobes
);

  logic upFlag;
  logic downFlag;
  logic wantUp;
  logic wantDown;

  // Sticky band flags: they collect events between ticks and clear on a tick.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upFlag   <= 1'b0;
      downFlag <= 1'b0;
    end else if (tick) begin
      upFlag   <= 1'b0;
      downFlag <= 1'b0;
    end else begin
      upFlag   <= upFlag | belowLow;
      downFlag <= downFlag | aboveHigh;
    end
  end

  // A band event in the tick cycle itself still belongs to the closing period.
  assign wantUp   = upFlag | belowLow;
  assign wantDown = downFlag | aboveHigh;

  always_comb begin
    strobes.preset = aboveReset;
    strobes.inc    = tick & wantUp & ~wantDown & ~aboveReset;
    strobes.dec    = tick & wantDown & ~wantUp & ~aboveReset;
  end

endmodule

// File: rtl/vcr_datapath.sv
module vcr_datapath
  import vcr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MIN_CNT = 1,
  parameter int MAX_CNT = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  vcrStrobes_t      strobes,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MinVal = CNT_W'(MIN_CNT);
  localparam logic [CNT_W-1:0] MaxVal = CNT_W'(MAX_CNT);

  logic atMax;
  logic atMin;

  assign atMax = (count == MaxVal);
  assign atMin = (count == MinVal);

  // Preset has priority; the up and down steps stop at the two limits.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= MinVal;
    end else if (strobes.preset) begin
      count <= MinVal;
    end else if (strobes.inc && !atMax) begin
      count <= count + 1'b1;
    end else if (strobes.dec && !atMin) begin
      count <= count - 1'b1;
    end
  end

endmodule

// File: rtl/valley_count_reg.sv
module valley_count_reg
  import vcr_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int MIN_CNT = 1,
  parameter int MAX_CNT = (1 << CNT_W) - 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             belowLow,
  input  logic             aboveHigh,
  input  logic             aboveReset,
  input  logic             tick,
  output logic [CNT_W-1:0] targetCount
);

  vcrStrobes_t strobes;

  vcr_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .belowLow   (belowLow),
    .aboveHigh  (aboveHigh),
    .aboveReset (aboveReset),
    .tick       (tick),
    .strobes    (strobes)
  );

  vcr_datapath #(
    .CNT_W   (CNT_W),
    .MIN_CNT (MIN_CNT),
    .MAX_CNT (MAX_CNT)
  ) u_dp (
    .clk     (clk),
    .rst_n   (rst_n),
    .strobes (strobes),
    .count   (targetCount)
  );

endmodule

// File: rtl/vcr_checker.sv
module vcr_checker #(
  parameter int CNT_W   = 4,
  parameter int MIN_CNT = 1,
  parameter int MAX_CNT = (1 << CNT_W) - 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             aboveReset,
  input logic             tick,
  input logic [CNT_W-1:0] targetCount
);

  // R11, R8, R9: the count stays within its limits
  assert_count_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (targetCount >= CNT_W'(MIN_CNT)) && (targetCount <= CNT_W'(MAX_CNT)));

  // R10: a load jump forces the minimum on the next edge
  assert_preset_min_R10: assert property (@(posedge clk) disable iff (!rst_n)
    aboveReset |=> (targetCount == CNT_W'(MIN_CNT)));

  // R6: with no tick and no preset, the count holds
  assert_hold_between_ticks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !aboveReset) |=> $stable(targetCount));

  // R2, R3: a tick moves the count by at most one
  assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !aboveReset) |=> ((targetCount == $past(targetCount)) ||
                               (targetCount == $past(targetCount) + 1'b1) ||
                               (targetCount == $past(targetCount) - 1'b1)));

endmodule

bind valley_count_reg vcr_checker #(
  .CNT_W   (CNT_W),
  .MIN_CNT (MIN_CNT),
  .MAX_CNT (MAX_CNT)
) u_vcr_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .aboveReset  (aboveReset),
  .tick        (tick),
  .targetCount (targetCount)
);

// File: tb/test_valley_count_reg.sv
module test_valley_count_reg;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       belowLow;
  logic       aboveHigh;
  logic       aboveReset;
  logic       tick;
  logic [3:0] targetCount;

  int testsRun = 0;
  int testsFailed = 0;

  always #2.5 clk = ~clk;

  valley_count_reg i_valley_count_reg (
    .clk         (clk),
    .rst_n       (rst_n),
    .belowLow    (belowLow),
    .aboveHigh   (aboveHigh),
    .aboveReset  (aboveReset),
    .tick        (tick),
    .targetCount (targetCount)
  );

  // Vector bits: {belowLow, aboveHigh, aboveReset, tick, expected[3:0]}
  localparam int NumVec = 18;
  localparam logic [7:0] Vecs [NumVec] = '{
    8'b1000_0001, // R6: low band seen, no tick
    8'b0000_0001, // R6
    8'b0001_0010, // R2: tick steps up
    8'b0001_0010, // R7: flag cleared, so the next tick holds
    8'b1001_0011, // R2: event in the tick cycle counts
    8'b0100_0011, // R6
    8'b0100_0011, // R6: still only one step per period
    8'b0001_0010, // R3: tick steps down
    8'b1000_0010, // R5: both bands seen
    8'b0100_0010, // R5
    8'b0001_0010, // R5: hold
    8'b0001_0010, // R4: quiet period, hold
    8'b1001_0011, // R2
    8'b0010_0001, // R10: preset without a tick
    8'b1000_0001, // R6
    8'b0001_0010, // R2
    8'b1011_0001, // R10: preset wins over the up step
    8'b0101_0001  // R9: floor at 1
  };

  localparam string VecTags [NumVec] = '{
    "R6", "R6", "R2", "R7", "R2", "R6", "R6", "R3", "R5",
    "R5", "R5", "R4", "R2", "R10", "R6", "R2", "R10", "R9"
  };

  task automatic check(input string tag, input logic [3:0] expected);
    testsRun++;
    if (targetCount !== expected) begin
      testsFailed++;
      $display("FAIL %s: targetCount=%0d expected=%0d", tag, targetCount, expected);
    end
  endtask

  task automatic step(input logic bl, input logic ah, input logic ar, input logic tk);
    belowLow   = bl;
    aboveHigh  = ah;
    aboveReset = ar;
    tick       = tk;
    @(negedge clk);
  endtask

  initial begin
    #100000;
    testsFailed++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("[TB] %0d tests run, %0d failed", testsRun + 1, testsFailed);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    belowLow = 1'b0;
    aboveHigh = 1'b0;
    aboveReset = 1'b0;
    tick = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", 4'd1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", 4'd1);

    for (int i = 0; i < NumVec; i++) begin
      step(Vecs[i][7], Vecs[i][6], Vecs[i][5], Vecs[i][4]);
      check(VecTags[i], Vecs[i][3:0]);
    end

    // R8: pump the count up; it stops at 15 and stays in range (R11)
    for (int i = 0; i < 18; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b1);
      check("R11", (i + 2 > 15) ? 4'd15 : 4'(i + 2));
    end
    check("R8", 4'd15);
    step(1'b1, 1'b0, 1'b0, 1'b1);
    check("R8", 4'd15);

    // R3: step back down from the top
    step(1'b0, 1'b1, 1'b0, 1'b1);
    check("R3", 4'd14);

    // R1: reset in mid-run returns the count to 1
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 4'd1);
    rst_n = 1'b1;
    step(1'b0, 1'b0, 1'b0, 1'b0);
    check("R1", 4'd1);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule